// File: doc/BRIEF.md
# Dispatch Credit Limiter

This block decides, every cycle, how many instructions the rename stage may pass on to dispatch. It keeps a local copy of the free-entry count of each of three downstream structures: the reorder buffer (ROB), the issue queue (IQ) and the load/store queue (LSQ). Each copy is refreshed only when the owning stage marks a fresh report as valid. Instructions that have been renamed but not yet dispatched still hold a claim on those entries. An in-flight counter tracks them and is subtracted from every stored count.

The smallest of the three corrected counts sets the credit. The grant is that credit, capped by the number of instructions waiting and by the rename width. When a structure limits the grant, the block raises a block request to the front end, reports which structure was the bottleneck, and bumps a full-event counter for that structure. A report from the ROB also carries an "ROB empty" flag, which the block holds and presents.

Top module: `dcl_limiter`

## Requirements
- R1: After reset the three stored free counts and the in-flight count are zero, the three event counters are zero and `rob_empty` is 1.
- R2: The ROB and IQ credits are the stored free count minus (in-flight count minus `disp_cnt`), as a signed value that may go negative.
- R3: The LSQ credit is the stored LSQ free count minus (in-flight count minus `lsq_disp_cnt`).
- R4: In a cycle with its valid flag high, a reported free count is used at once and stored at the clock edge. With the flag low, the stored value is used and kept unchanged. A valid ROB report also loads `rob_empty` from `rob_empty_in`.
- R5: The limiting credit is the minimum of the three. On a tie the ROB wins over the IQ, and the IQ wins over the LSQ. `limit_src` reports the winner as 0 for the ROB, 1 for the IQ and 2 for the LSQ, and never shows 3.
- R6: With instructions waiting (`avail_cnt` > 0) and a minimum credit of zero or less, `grant_cnt` is 0 and `block_req` is 1.
- R7: With a positive minimum credit below `avail_cnt`, the grant equals that minimum (capped by R8) and `block_req` is 1.
- R8: `grant_cnt` never exceeds the rename width or `avail_cnt`. With `avail_cnt` = 0 the grant is 0 and `block_req` is 0.
- R9: At each clock edge the in-flight count grows by `renamed_cnt` and shrinks by `disp_cnt`. It never goes below zero.
- R10: Each event counter increments by one in every cycle in which `block_req` is raised and `limit_src` names its structure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rob_free_vld | input | 1 | ROB free-count report valid |
| rob_free_cnt | input | CW | Reported ROB free entries |
| rob_empty_in | input | 1 | Reported ROB empty flag |
| iq_free_vld | input | 1 | IQ free-count report valid |
| iq_free_cnt | input | CW | Reported IQ free entries |
| lsq_free_vld | input | 1 | LSQ free-count report valid |
| lsq_free_cnt | input | CW | Reported LSQ free entries |
| disp_cnt | input | IW | Instructions dispatched this cycle |
| lsq_disp_cnt | input | IW | Instructions dispatched to the LSQ this cycle |
| avail_cnt | input | AW | Instructions waiting to be renamed |
| renamed_cnt | input | GW | Instructions actually renamed this cycle |
| grant_cnt | output | GW | Instructions allowed to be renamed this cycle |
| block_req | output | 1 | Request to stall the front end |
| limit_src | output | 2 | Bottleneck structure: 0 ROB, 1 IQ, 2 LSQ |
| rob_empty | output | 1 | Stored ROB empty flag |
| rob_evt_cnt | output | EW | Cycles limited by the ROB |
| iq_evt_cnt | output | EW | Cycles limited by the IQ |
| lsq_evt_cnt | output | EW | Cycles limited by the LSQ |

## Verification
The assertions assume that the neighbouring stages keep their side of the contract. `disp_cnt` never exceeds the current in-flight count, and `renamed_cnt` never exceeds the grant of the same cycle. The in-flight no-underflow check depends on both. The stimulus tracks its own in-flight model and draws `disp_cnt` and `lsq_disp_cnt` from zero up to that model value. It draws `renamed_cnt` from zero up to the expected grant, and stops renaming when the model nears the counter's range.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  typedef enum logic [1:0] {
    SRC_ROB = 2'd0,
    SRC_IQ  = 2'd1,
    SRC_LSQ = 2'd2
  } src_e;
endpackage

// File: rtl/dcl_count_hold.sv
module dcl_count_hold #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] val_in,
  output logic [W-1:0] q,
  output logic [W-1:0] eff
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= val_in;
  end

  // a fresh report is used in the cycle it arrives
  assign eff = upd ? val_in : q;
endmodule

// File: rtl/dcl_inflight.sv
module dcl_inflight #(
  parameter int IW = 6,
  parameter int GW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] add,
  input  logic [IW-1:0] sub,
  output logic [IW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q + IW'(add) - sub;
  end
endmodule

// File: rtl/dcl_select.sv
module dcl_select
  import dcl_pkg::*;
#(
  parameter int CW    = 6,
  parameter int IW    = 6,
  parameter int AW    = 4,
  parameter int GW    = 3,
  parameter int SW    = 8,
  parameter int WIDTH = 4
) (
  input  logic [CW-1:0]        rob_f,
  input  logic [CW-1:0]        iq_f,
  input  logic [CW-1:0]        lsq_f,
  input  logic [IW-1:0]        infl,
  input  logic [IW-1:0]        disp,
  input  logic [IW-1:0]        lsq_disp,
  input  logic [AW-1:0]        avail,
  output logic signed [SW-1:0] min_free,
  output src_e                 src,
  output logic [GW-1:0]        grant,
  output logic                 limited
);
  localparam logic signed [SW-1:0] WIDTH_S = SW'(WIDTH);

  function automatic logic signed [SW-1:0] net_free(
    input logic [CW-1:0] f, input logic [IW-1:0] n, input logic [IW-1:0] d);
    return SW'(f) - (SW'(n) - SW'(d));
  endfunction

  logic signed [SW-1:0] c_rob, c_iq, c_lsq, avail_s, cap;

  always_comb begin
    c_rob   = net_free(rob_f, infl, disp);
    c_iq    = net_free(iq_f, infl, disp);
    c_lsq   = net_free(lsq_f, infl, lsq_disp);
    avail_s = SW'(avail);
    min_free = c_rob;
    src      = SRC_ROB;
    if (c_iq < min_free)  begin min_free = c_iq;  src = SRC_IQ;  end
    if (c_lsq < min_free) begin min_free = c_lsq; src = SRC_LSQ; end
    limited = (avail != '0) && ((min_free <= 0) || (min_free < avail_s));
    cap = min_free;
    if (avail_s < cap) cap = avail_s;
    if (WIDTH_S < cap) cap = WIDTH_S;
    if (cap <= 0) grant = '0;
    else          grant = GW'(cap);
  end
endmodule

// File: rtl/dcl_limiter.sv
module dcl_limiter
  import dcl_pkg::*;
#(
  parameter int CW    = 6,
  parameter int IW    = 6,
  parameter int AW    = 4,
  parameter int WIDTH = 4,
  parameter int EW    = 8,
  localparam int GW   = $clog2(WIDTH + 1),
  localparam int MW   = (CW > IW) ? ((CW > AW) ? CW : AW) : ((IW > AW) ? IW : AW),
  localparam int SW   = MW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rob_free_vld,
  input  logic [CW-1:0] rob_free_cnt,
  input  logic          rob_empty_in,
  input  logic          iq_free_vld,
  input  logic [CW-1:0] iq_free_cnt,
  input  logic          lsq_free_vld,
  input  logic [CW-1:0] lsq_free_cnt,
  input  logic [IW-1:0] disp_cnt,
  input  logic [IW-1:0] lsq_disp_cnt,
  input  logic [AW-1:0] avail_cnt,
  input  logic [GW-1:0] renamed_cnt,
  output logic [GW-1:0] grant_cnt,
  output logic          block_req,
  output logic [1:0]    limit_src,
  output logic          rob_empty,
  output logic [EW-1:0] rob_evt_cnt,
  output logic [EW-1:0] iq_evt_cnt,
  output logic [EW-1:0] lsq_evt_cnt
);
  localparam int NSRC = 3;

  logic [NSRC-1:0]         upd;
  logic [CW-1:0]           rep   [NSRC];
  logic [CW-1:0]           held  [NSRC];
  logic [CW-1:0]           eff   [NSRC];
  logic [EW-1:0]           evt_q [NSRC];
  logic [IW-1:0]           inflight;
  logic signed [SW-1:0]    min_free;
  logic                    limited;
  src_e                    src;

  assign upd = {lsq_free_vld, iq_free_vld, rob_free_vld};
  assign rep[0] = rob_free_cnt;
  assign rep[1] = iq_free_cnt;
  assign rep[2] = lsq_free_cnt;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    dcl_count_hold #(.W(CW)) u_hold (
      .clk(clk), .rst_n(rst_n), .upd(upd[i]), .val_in(rep[i]),
      .q(held[i]), .eff(eff[i]));

    always_ff @(posedge clk) begin
      if (!rst_n) evt_q[i] <= '0;
      else if (limited && (src == src_e'(i))) evt_q[i] <= evt_q[i] + 1'b1;
    end
  end

  dcl_inflight #(.IW(IW), .GW(GW)) u_infl (
    .clk(clk), .rst_n(rst_n), .add(renamed_cnt), .sub(disp_cnt), .q(inflight));

  dcl_select #(.CW(CW), .IW(IW), .AW(AW), .GW(GW), .SW(SW), .WIDTH(WIDTH)) u_sel (
    .rob_f(eff[0]), .iq_f(eff[1]), .lsq_f(eff[2]),
    .infl(inflight), .disp(disp_cnt), .lsq_disp(lsq_disp_cnt), .avail(avail_cnt),
    .min_free(min_free), .src(src), .grant(grant_cnt), .limited(limited));

  always_ff @(posedge clk) begin
    if (!rst_n)            rob_empty <= 1'b1;
    else if (rob_free_vld) rob_empty <= rob_empty_in;
  end

  assign block_req   = limited;
  assign limit_src   = src;
  assign rob_evt_cnt = evt_q[0];
  assign iq_evt_cnt  = evt_q[1];
  assign lsq_evt_cnt = evt_q[2];
endmodule

// File: rtl/dcl_limiter_chk.sv
module dcl_limiter_chk #(
  parameter int IW    = 6,
  parameter int AW    = 4,
  parameter int GW    = 3,
  parameter int CW    = 6,
  parameter int SW    = 8,
  parameter int EW    = 8,
  parameter int WIDTH = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [GW-1:0]        grant_cnt,
  input logic                 block_req,
  input logic [1:0]           limit_src,
  input logic [AW-1:0]        avail_cnt,
  input logic [IW-1:0]        disp_cnt,
  input logic [IW-1:0]        inflight,
  input logic signed [SW-1:0] min_free,
  input logic                 rob_free_vld,
  input logic [CW-1:0]        rob_held,
  input logic [EW-1:0]        rob_evt_cnt
);
  a_r8_grant_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(grant_cnt) <= WIDTH) && (32'(grant_cnt) <= 32'(avail_cnt)));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_cnt == '0) |-> (!block_req && grant_cnt == '0));

  a_r6_starved_block: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_cnt != '0 && min_free <= 0) |-> (block_req && grant_cnt == '0));

  a_r5_src_legal: assert property (@(posedge clk) disable iff (!rst_n)
    limit_src != 2'd3);

  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    disp_cnt <= inflight);

  a_r4_hold_rob: assert property (@(posedge clk) disable iff (!rst_n)
    !rob_free_vld |=> rob_held == $past(rob_held));

  a_r10_rob_event: assert property (@(posedge clk) disable iff (!rst_n)
    (block_req && limit_src == 2'd0) |=> rob_evt_cnt == $past(rob_evt_cnt) + 1'b1);
endmodule

bind dcl_limiter dcl_limiter_chk #(
  .IW(IW), .AW(AW), .GW(GW), .CW(CW), .SW(SW), .EW(EW), .WIDTH(WIDTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grant_cnt(grant_cnt), .block_req(block_req),
  .limit_src(limit_src), .avail_cnt(avail_cnt), .disp_cnt(disp_cnt),
  .inflight(inflight), .min_free(min_free), .rob_free_vld(rob_free_vld),
  .rob_held(held[0]), .rob_evt_cnt(rob_evt_cnt));

// File: tb/dcl_limiter_test.sv
module dcl_limiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 4;

  logic clk = 0, rst_n = 0;
  logic rob_free_vld = 0, iq_free_vld = 0, lsq_free_vld = 0, rob_empty_in = 0;
  logic [5:0] rob_free_cnt = 0, iq_free_cnt = 0, lsq_free_cnt = 0;
  logic [5:0] disp_cnt = 0, lsq_disp_cnt = 0;
  logic [3:0] avail_cnt = 0;
  logic [2:0] renamed_cnt = 0;
  logic [2:0] grant_cnt;
  logic       block_req, rob_empty;
  logic [1:0] limit_src;
  logic [7:0] rob_evt_cnt, iq_evt_cnt, lsq_evt_cnt;

  int n_cmp = 0, n_bad = 0;
  int m_rob = 0, m_iq = 0, m_lsq = 0, m_infl = 0, m_empty = 1;
  int m_ev[3] = '{0, 0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  dcl_limiter uut (.*);

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int credit(input int f, input int n, input int d);
    return f - n + d;
  endfunction

  task automatic step(input bit rv, input int rf, input bit re,
                      input bit iv, input int ifr, input bit lv, input int lf,
                      input int d, input int ld, input int av, input bit rnd);
    int er, ei, el, mn, src, g, blk, ren;
    @(negedge clk);
    rob_free_vld = rv; rob_free_cnt = 6'(rf); rob_empty_in = re;
    iq_free_vld = iv; iq_free_cnt = 6'(ifr);
    lsq_free_vld = lv; lsq_free_cnt = 6'(lf);
    disp_cnt = 6'(d); lsq_disp_cnt = 6'(ld); avail_cnt = 4'(av); renamed_cnt = 0;
    #1;
    // R4: a valid report is used in the same cycle
    er = credit(rv ? rf : m_rob, m_infl, d);
    ei = credit(iv ? ifr : m_iq, m_infl, d);
    el = credit(lv ? lf : m_lsq, m_infl, ld);
    mn = er; src = 0;
    if (ei < mn) begin mn = ei; src = 1; end
    if (el < mn) begin mn = el; src = 2; end
    if (av == 0) begin g = 0; blk = 0; end
    else if (mn <= 0) begin g = 0; blk = 1; end
    else begin
      g = mn; if (av < g) g = av; if (WIDTH < g) g = WIDTH;
      blk = (mn < av) ? 1 : 0;
    end
    chk("R2 R3 R4 R7 R8 R9 grant", int'(grant_cnt), g);
    chk("R6 R7 R8 block", int'(block_req), blk);
    chk("R5 source", int'(limit_src), src);
    chk("R4 rob_empty", int'(rob_empty), m_empty);
    chk("R10 rob events", int'(rob_evt_cnt), m_ev[0] % 256);
    chk("R10 iq events", int'(iq_evt_cnt), m_ev[1] % 256);
    chk("R10 lsq events", int'(lsq_evt_cnt), m_ev[2] % 256);
    ren = g;
    if (rnd) ren = $urandom_range(0, g);
    if (m_infl > 50) ren = 0;
    renamed_cnt = 3'(ren);
    @(posedge clk);
    if (rv) begin m_rob = rf; m_empty = re; end
    if (iv) m_iq = ifr;
    if (lv) m_lsq = lf;
    m_infl = m_infl + ren - d;
    if (blk) m_ev[src]++;
  endtask

  initial begin
    automatic int seed = 32'h5eed_0d1c;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1: reset state, stored counts all zero so ROB wins the tie
    chk("R1 grant", int'(grant_cnt), 0);
    chk("R1 block idle", int'(block_req), 0);
    chk("R1 rob_empty", int'(rob_empty), 1);
    chk("R1 events", int'(rob_evt_cnt) + int'(iq_evt_cnt) + int'(lsq_evt_cnt), 0);
    step(0,0,0, 0,0, 0,0, 0,0, 3, 0);     // R6 zero credit, ROB tie winner
    step(1,5,0, 1,5, 1,5, 0,0, 8, 0);     // R5 tie, R7 cut to 5 -> 4 by width
    step(0,0,0, 0,0, 0,0, 0,0, 0, 0);     // R8 nothing waiting
    step(1,20,1, 1,3, 1,3, 0,0, 6, 0);    // R5 IQ beats LSQ on tie
    step(1,20,0, 1,20, 1,20, 0,0, 9, 0);  // R8 width cap, no block
    step(0,0,0, 0,0, 0,0, 4,0, 2, 0);     // R2 R3 dispatch credits back
    step(0,0,0, 0,0, 1,1, 0,0, 5, 0);     // R3 LSQ limits
    step(0,0,0, 0,0, 0,0, 0,0, 5, 0);     // R4 held values
    for (int i = 0; i < 3000; i++) begin
      automatic int d  = $urandom_range(0, m_infl);
      automatic int ld = $urandom_range(0, m_infl);
      step($urandom_range(0,2) == 0, $urandom_range(0,40), $urandom_range(0,1),
           $urandom_range(0,2) == 0, $urandom_range(0,40),
           $urandom_range(0,2) == 0, $urandom_range(0,40),
           d, ld, $urandom_range(0,12), 1);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule